// File: doc/BRIEF.md
# Dual-View Channel Interrupt Register File

This block is the interrupt-status corner of a two-channel disk controller's configuration space. Each channel has one interrupt flag. Software can see that flag through two different configuration bytes. Whichever byte software reads, it gets the same value, and clearing the flag through either byte clears it in both. The channel engines raise the flags. A combined level-sensitive interrupt line goes high while any unmasked flag is set.

The block also holds three other things. The first is the per-channel enable bits. The second is the two per-channel interrupt mask bits, which are loaded only through the bus-master register port. The third is a small per-channel bus-master status byte, which has its own clear-on-write rules.

Configuration writes are dword-addressed with four byte enables. Reads return the whole dword at a read address, combinationally from the stored state. Offsets that are not listed below read as zero.

Top module: `mirrored_irq_regs`

## Requirements
- R1: The channel 0 flag reads at offset 0x50 bit 2 and at offset 0x71 bit 2. The channel 1 flag reads at offset 0x57 bit 4 and at offset 0x71 bit 3. Both views of a flag always read the same value.
- R2: A configuration write clears a flag only where an enabled byte at 0x50, 0x57 or 0x71 carries a 1 in that flag's bit. Writing 0 leaves the flag unchanged. No other bit of those three bytes changes through the configuration port, and those other bits read 0, except the mask bits at 0x71 (R5).
- R3: A clear through either view of a flag shows up in both views on the cycle after the write.
- R4: A high `ch_irq_set_i[c]` sets flag c in both views on the next cycle. If a set and a clearing write reach the same flag in the same cycle, the set wins.
- R5: A bus-master write with `bm_addr_i`=1 loads offset 0x71 bits 5:4 (bit 4 masks channel 0, bit 5 masks channel 1) from `bm_wdata_i[5:4]`, whichever channel `bm_ch_i` selects. The flags are unchanged.
- R6: `irq_o` is high exactly when (flag0 and not mask0) or (flag1 and not mask1), and it follows the state with no added latency.
- R7: Each channel's status byte is laid out as follows.
  - Bit 0 is registered from `ch_active_i[c]` every cycle.
  - Bit 1 is set by `ch_err_i[c]`.
  - Bit 2 is set by `ch_irq_set_i[c]`.
  - Bits 6:5 are control bits. Bits 7, 4 and 3 read 0.
  - A bus-master write with `bm_addr_i`=2 to channel `bm_ch_i` loads bits 6:5 from the data. It clears bit 1 or bit 2 wherever the data has a 1, unless the matching event is high in that same cycle. It never affects bit 0.
- R8: Offset 0x51 bits 2 and 3 are read/write enables for channels 0 and 1. They drive `ch_en_o`. The other bits of 0x51 read 0.
- R9: After reset, both flags, both masks and both status bytes are 0, and both channel enables are 1.
- R10: Any offset other than 0x50, 0x51, 0x57 and 0x71 reads 0. A byte whose enable is low is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration write address (bits 1:0 ignored) |
| cfg_be_i | input | 4 | Configuration write byte enables |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_raddr_i | input | 8 | Configuration read address (bits 1:0 ignored) |
| cfg_rdata_o | output | 32 | Configuration read data for the addressed dword |
| bm_we_i | input | 1 | Bus-master register write strobe |
| bm_ch_i | input | 1 | Bus-master target channel |
| bm_addr_i | input | 2 | Bus-master sub-address (1 = masks, 2 = status) |
| bm_wdata_i | input | 8 | Bus-master write data |
| bm_status_o | output | 16 | Status bytes, channel 1 in bits 15:8 |
| ch_irq_set_i | input | 2 | Per-channel interrupt raise |
| ch_err_i | input | 2 | Per-channel error raise |
| ch_active_i | input | 2 | Per-channel transfer-active level |
| ch_en_o | output | 2 | Channel enables |
| irq_o | output | 1 | Combined level interrupt |

## Verification
The bench first goes after the places where the two views could drift apart.
- It clears through one view and reads the other. A design that stored each view separately would keep the stale view set.
- It writes zeros and non-flag ones to the flag bytes. A design that treated those bytes as plain registers would drop a flag or pick up mask bits through the configuration port.
- It collides a raise with a clear on the same channel. A clear-priority design would lose the interrupt.

It also writes masks through the bus-master port with either channel selected, and checks that only the line changes. Bus-master status writes are checked to hold the active bit and to clear only where ones were written. Beyond these directed cases, long random traffic is compared every cycle against a behavioural model. That comparison covers byte-enable misuse and reads of unlisted offsets.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int unsigned NCH = 2;
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

  localparam logic [7:0] OFS_STAT0 = 8'h50;
  localparam logic [7:0] OFS_CHEN  = 8'h51;
  localparam logic [7:0] OFS_STAT1 = 8'h57;
  localparam logic [7:0] OFS_MODE  = 8'h71;

  localparam int unsigned STAT0_BIT     = 2;
  localparam int unsigned STAT1_BIT     = 4;
  localparam int unsigned MODE_FLAG_LSB = 2;
  localparam int unsigned MODE_MASK_LSB = 4;
  localparam int unsigned CHEN_LSB      = 2;

  localparam logic [1:0] BM_SUB_MODE = 2'd1;
  localparam logic [1:0] BM_SUB_STAT = 2'd2;

  function automatic logic byte_hit(logic [7:0] a, logic [3:0] be, logic [7:0] ofs);
    return (a[7:2] == ofs[7:2]) && be[ofs[1:0]];
  endfunction

  function automatic logic [7:0] byte_of(logic [31:0] d, logic [7:0] ofs);
    return d[8*ofs[1:0] +: 8];
  endfunction
endpackage

// File: rtl/mirq_cfg_decode.sv
module mirq_cfg_decode
  import mirq_pkg::*;
(
  input  logic            we_i,
  input  logic [7:0]      addr_i,
  input  logic [3:0]      be_i,
  input  logic [31:0]     wdata_i,
  output logic [NCH-1:0]  clr_o,
  output logic            en_we_o,
  output logic [NCH-1:0]  en_wdata_o
);
  logic [7:0] mode_b, chen_b;
  assign mode_b = byte_of(wdata_i, OFS_MODE);
  assign chen_b = byte_of(wdata_i, OFS_CHEN);

  for (genvar c = 0; c < NCH; c++) begin : g_clr
    localparam logic [7:0]  VA_OFS = (c == 0) ? OFS_STAT0 : OFS_STAT1;
    localparam int unsigned VA_BIT = (c == 0) ? STAT0_BIT : STAT1_BIT;
    logic [7:0] va_b;
    logic       hit_a, hit_b;
    assign va_b  = byte_of(wdata_i, VA_OFS);
    assign hit_a = byte_hit(addr_i, be_i, VA_OFS) && va_b[VA_BIT];
    assign hit_b = byte_hit(addr_i, be_i, OFS_MODE) && mode_b[MODE_FLAG_LSB+c];
    assign clr_o[c] = we_i && (hit_a || hit_b);
  end

  assign en_we_o    = we_i && byte_hit(addr_i, be_i, OFS_CHEN);
  assign en_wdata_o = chen_b[CHEN_LSB +: NCH];
endmodule

// File: rtl/mirq_flag_cell.sv
module mirq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // raise beats clear
    else if (clr_i) flag_o <= 1'b0;
  end

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  p_w1c_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  p_w1c_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/mirq_bm_status.sv
module mirq_bm_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       active_i,
  input  logic       err_i,
  input  logic       irq_set_i,
  output logic [7:0] status_o
);
  logic       act_q, err_q, irq_q;
  logic [1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      ctl_q <= '0;
    end else begin
      act_q <= active_i;
      err_q <= err_i     | (err_q & ~(we_i & wdata_i[1]));
      irq_q <= irq_set_i | (irq_q & ~(we_i & wdata_i[2]));
      if (we_i) ctl_q <= wdata_i[6:5];
    end
  end

  assign status_o = {1'b0, ctl_q, 2'b00, irq_q, err_q, act_q};

  p_active_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> status_o[0] == $past(active_i));
  p_ctl_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> status_o[6:5] == $past(wdata_i[6:5]));
  p_zero_no_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[2] && status_o[2]) |=> status_o[2]);
endmodule

// File: rtl/mirrored_irq_regs.sv
module mirrored_irq_regs
  import mirq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_addr_i,
  input  logic [3:0]      cfg_be_i,
  input  logic [31:0]     cfg_wdata_i,
  input  logic [7:0]      cfg_raddr_i,
  output logic [31:0]     cfg_rdata_o,
  input  logic            bm_we_i,
  input  logic [CHW-1:0]  bm_ch_i,
  input  logic [1:0]      bm_addr_i,
  input  logic [7:0]      bm_wdata_i,
  output logic [8*NCH-1:0] bm_status_o,
  input  logic [NCH-1:0]  ch_irq_set_i,
  input  logic [NCH-1:0]  ch_err_i,
  input  logic [NCH-1:0]  ch_active_i,
  output logic [NCH-1:0]  ch_en_o,
  output logic            irq_o
);
  logic [NCH-1:0] clr, flag, mask_q, en_wdata;
  logic           en_we, mode_we;

  mirq_cfg_decode u_dec (
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .be_i       (cfg_be_i),
    .wdata_i    (cfg_wdata_i),
    .clr_o      (clr),
    .en_we_o    (en_we),
    .en_wdata_o (en_wdata)
  );

  // one storage bit per channel: both views read it
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic st_we;
    assign st_we = bm_we_i && (bm_addr_i == BM_SUB_STAT) && (bm_ch_i == CHW'(c));

    mirq_flag_cell u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ch_irq_set_i[c]),
      .clr_i  (clr[c]),
      .flag_o (flag[c])
    );

    mirq_bm_status u_st (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (st_we),
      .wdata_i   (bm_wdata_i),
      .active_i  (ch_active_i[c]),
      .err_i     (ch_err_i[c]),
      .irq_set_i (ch_irq_set_i[c]),
      .status_o  (bm_status_o[8*c +: 8])
    );
  end

  assign mode_we = bm_we_i && (bm_addr_i == BM_SUB_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      ch_en_o <= '1;
    end else begin
      if (mode_we) mask_q  <= bm_wdata_i[MODE_MASK_LSB +: NCH];
      if (en_we)   ch_en_o <= en_wdata;
    end
  end

  assign irq_o = |(flag & ~mask_q);

  always_comb begin
    cfg_rdata_o = '0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a, b;
      a = {cfg_raddr_i[7:2], 2'(k)};
      b = '0;
      case (a)
        OFS_STAT0: b[STAT0_BIT] = flag[0];
        OFS_STAT1: b[STAT1_BIT] = flag[1];
        OFS_CHEN:  b[CHEN_LSB +: NCH] = ch_en_o;
        OFS_MODE: begin
          b[MODE_FLAG_LSB +: NCH] = flag;
          b[MODE_MASK_LSB +: NCH] = mask_q;
        end
        default: b = '0;
      endcase
      cfg_rdata_o[8*k +: 8] = b;
    end
  end

  p_mask_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
  p_mode_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we |=> mask_q == $past(bm_wdata_i[MODE_MASK_LSB +: NCH]));
  p_mode_keeps_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we && !cfg_we_i && !(|ch_irq_set_i)) |=> $stable(flag));
  p_en_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we |=> $stable(ch_en_o));
endmodule

// File: tb/mirrored_irq_regs_tb_top.sv
module mirrored_irq_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [7:0]  cfg_addr_i, cfg_raddr_i;
  logic [3:0]  cfg_be_i;
  logic [31:0] cfg_wdata_i, cfg_rdata_o;
  logic        bm_we_i;
  logic [0:0]  bm_ch_i;
  logic [1:0]  bm_addr_i;
  logic [7:0]  bm_wdata_i;
  logic [15:0] bm_status_o;
  logic [1:0]  ch_irq_set_i, ch_err_i, ch_active_i, ch_en_o;
  logic        irq_o;

  always #5 clk_i = ~clk_i;

  mirrored_irq_regs dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  bit       m_f0, m_f1, m_k0, m_k1;
  bit [1:0] m_en;
  bit [7:0] m_st [2];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_f0 = 0; m_f1 = 0; m_k0 = 0; m_k1 = 0; m_en = 2'b11;
      m_st[0] = 0; m_st[1] = 0;
    end else begin
      bit c0, c1;
      c0 = cfg_we_i && ((cfg_addr_i[7:2] == 6'h14 && cfg_be_i[0] && cfg_wdata_i[2]) ||
                        (cfg_addr_i[7:2] == 6'h1C && cfg_be_i[1] && cfg_wdata_i[10]));
      c1 = cfg_we_i && ((cfg_addr_i[7:2] == 6'h15 && cfg_be_i[3] && cfg_wdata_i[28]) ||
                        (cfg_addr_i[7:2] == 6'h1C && cfg_be_i[1] && cfg_wdata_i[11]));
      if (cfg_we_i && cfg_addr_i[7:2] == 6'h14 && cfg_be_i[1]) m_en = cfg_wdata_i[11:10];
      if (bm_we_i && bm_addr_i == 1) begin m_k0 = bm_wdata_i[4]; m_k1 = bm_wdata_i[5]; end
      if (ch_irq_set_i[0]) m_f0 = 1; else if (c0) m_f0 = 0;
      if (ch_irq_set_i[1]) m_f1 = 1; else if (c1) m_f1 = 0;
      for (int c = 0; c < 2; c++) begin
        bit w;
        w = bm_we_i && bm_addr_i == 2 && bm_ch_i == 1'(c);
        m_st[c][0] = ch_active_i[c];
        if (ch_err_i[c]) m_st[c][1] = 1; else if (w && bm_wdata_i[1]) m_st[c][1] = 0;
        if (ch_irq_set_i[c]) m_st[c][2] = 1; else if (w && bm_wdata_i[2]) m_st[c][2] = 0;
        if (w) m_st[c][6:5] = bm_wdata_i[6:5];
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a[7:2])
      6'h14:   return {16'h0, 4'h0, m_en, 2'b00, 5'h0, m_f0, 2'b00};
      6'h15:   return {3'b000, m_f1, 4'h0, 24'h0};
      6'h1C:   return {16'h0, 2'b00, m_k1, m_k0, m_f1, m_f0, 2'b00, 8'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    bit impl;
    impl = cfg_raddr_i[7:2] inside {6'h14, 6'h15, 6'h1C};
    chk(impl ? "R1 read view" : "R10 unlisted read", cfg_rdata_o, exp_rd(cfg_raddr_i));
    chk("R6 irq", {31'b0, irq_o}, {31'b0, (m_f0 & ~m_k0) | (m_f1 & ~m_k1)});
    chk("R7 status", {16'b0, bm_status_o}, {16'b0, m_st[1], m_st[0]});
    chk("R8 enables", {30'b0, ch_en_o}, {30'b0, m_en});
  endtask

  task automatic idle();
    cfg_we_i = 0; cfg_addr_i = 0; cfg_be_i = 0; cfg_wdata_i = 0;
    bm_we_i = 0; bm_ch_i = 0; bm_addr_i = 0; bm_wdata_i = 0;
    ch_irq_set_i = 0; ch_err_i = 0; ch_active_i = 0;
  endtask

  task automatic tick();
    @(negedge clk_i);
    cmp_all();
  endtask

  task automatic cfg_wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    cfg_we_i = 1; cfg_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    cfg_raddr_i = a;
    #1;
    chk(tag, cfg_rdata_o, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    cfg_raddr_i = 8'h50;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R9 reset state
    chk("R9 reset 0x50", cfg_rdata_o, 32'h0000_0C00);
    rd_chk("R9 reset 0x71", 8'h70, 32'h0);
    chk("R9 reset irq", {31'b0, irq_o}, 32'h0);
    chk("R9 reset status", {16'b0, bm_status_o}, 32'h0);
    chk("R9 reset enables", {30'b0, ch_en_o}, 32'h3);

    // R4: raise ch0, both views
    ch_irq_set_i = 2'b01; tick(); idle();
    rd_chk("R4 raise ch0 at 0x71", 8'h70, 32'h0000_0400);
    rd_chk("R1 ch0 at 0x50", 8'h50, 32'h0000_0C04);
    chk("R6 irq after raise", {31'b0, irq_o}, 32'h1);

    // R2: zero in flag bit, ones in mask bits via config: no effect
    cfg_wr(8'h70, 4'b0010, 32'h0000_3000); tick(); idle();
    rd_chk("R2 write zero keeps flag", 8'h70, 32'h0000_0400);
    // R10: flag bit set but byte disabled
    cfg_wr(8'h50, 4'b1110, 32'hFFFF_FFFF); tick(); idle();
    rd_chk("R10 disabled byte ignored", 8'h70, 32'h0000_0400);

    // R3: clear at 0x50 shows at 0x71
    cfg_wr(8'h50, 4'b0001, 32'h0000_0004); tick(); idle();
    rd_chk("R3 clear via 0x50", 8'h70, 32'h0);

    // R4: raise and clear ch1 together
    ch_irq_set_i = 2'b10; cfg_wr(8'h54, 4'b1000, 32'h1000_0000); tick(); idle();
    rd_chk("R4 set wins", 8'h54, 32'h1000_0000);

    // R5: mask ch1 via bus-master port, other channel selected
    bm_we_i = 1; bm_ch_i = 0; bm_addr_i = 2'd1; bm_wdata_i = 8'hEF; tick(); idle();
    rd_chk("R5 mask load", 8'h70, 32'h0000_2800);
    chk("R6 masked flag", {31'b0, irq_o}, 32'h0);
    bm_we_i = 1; bm_ch_i = 1; bm_addr_i = 2'd1; bm_wdata_i = 8'h00; tick(); idle();
    chk("R6 unmasked flag", {31'b0, irq_o}, 32'h1);

    // R3: clear ch1 via 0x71, read at 0x57
    cfg_wr(8'h70, 4'b0010, 32'h0000_0800); tick(); idle();
    rd_chk("R3 clear via 0x71", 8'h54, 32'h0);

    // R8 enables
    cfg_wr(8'h50, 4'b0010, 32'h0000_0400); tick(); idle();
    rd_chk("R8 enable write", 8'h50, 32'h0000_0400);
    chk("R8 ch_en_o", {30'b0, ch_en_o}, 32'h1);
    rd_chk("R10 unlisted", 8'h60, 32'h0);

    // R7 status byte
    ch_active_i = 2'b01; ch_err_i = 2'b01; ch_irq_set_i = 2'b01; tick();
    ch_err_i = 0; ch_irq_set_i = 0; tick();
    chk("R7 status raised", {24'b0, bm_status_o[7:0]}, 32'h07);
    bm_we_i = 1; bm_ch_i = 0; bm_addr_i = 2'd2; bm_wdata_i = 8'hFF; tick();
    bm_we_i = 0;
    chk("R7 status write", {24'b0, bm_status_o[7:0]}, 32'h61);
    bm_we_i = 1; bm_wdata_i = 8'h00; tick(); idle();
    chk("R7 zero write keeps bit0 state", {24'b0, bm_status_o[7:0]}, 32'h01);
    tick();

    // random traffic compared every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] addrs [4];
      addrs = '{8'h50, 8'h54, 8'h70, 8'h60};
      idle();
      cfg_raddr_i = addrs[$urandom_range(3)];
      if ($urandom_range(2) == 0)
        cfg_wr(addrs[$urandom_range(3)], 4'($urandom), $urandom);
      if ($urandom_range(3) == 0) begin
        bm_we_i = 1; bm_ch_i = 1'($urandom); bm_addr_i = 2'($urandom); bm_wdata_i = 8'($urandom);
      end
      ch_irq_set_i = {($urandom_range(7) == 0), ($urandom_range(7) == 0)};
      ch_err_i     = {($urandom_range(9) == 0), ($urandom_range(9) == 0)};
      ch_active_i  = 2'($urandom);
      tick();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule